// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupt Triggers

This block controls up to 32 general-purpose pins through a small bank of 32-bit registers addressed by word index, with one write strobe and one read strobe. Software selects per pin whether it drives or listens. It sets the level driven on output pins and reads back the synchronized level of every pin. The pad buffers are not part of the block. It hands out an output-enable vector and an output-data vector, and takes in the pad levels as a plain input vector.

Each pin also feeds an interrupt detector. Three per-pin controls choose the trigger: a mode select (edge or level), a sense bit (high/rising or low/falling) and a dual-edge override. Detected edges are latched in a raw status register until software clears them by writing ones. For level-triggered pins, raw status tracks the qualified input level. A masked view (raw status AND enable) is readable, and one interrupt line is high whenever any masked bit is set. A version register reads 3, which tells software that the dual-edge control is present.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, `irq`, `pin_oe` and `pin_do` are 0. Enable, raw status, value, mode-select and dual-edge registers read 0. Direction reads all ones (every pin an input). Sense reads all ones, so the reset trigger is level-high.
- R2: Direction is word 1. A bit of 1 makes the pin an input (`pin_oe` bit 0) and a bit of 0 makes it an output (`pin_oe` bit 1). `pin_oe` changes in the cycle after the write.
- R3: Writing word 0 sets `pin_do` in the cycle after the write. Reading word 0 returns `pin_in` after a two-flop synchronizer.
- R4: When the mode bit (word 6) is 0, the pin is level-triggered. With sense bit (word 7) 1, raw status (word 3) follows the synchronized level. With sense bit 0, raw status follows its inverse. Raw status is updated one cycle after the synchronizer output.
- R5: When the mode bit is 1 and the dual-edge bit is 0, raw status latches a rising edge if the sense bit is 1 and a falling edge if the sense bit is 0. The latched bit stays set until cleared.
- R6: When the dual-edge bit (word 9) and the mode bit are both 1, both edge directions set raw status and the sense bit has no effect.
- R7: Writing word 5 clears the raw status bits written as 1 and leaves bits written as 0 unchanged. An edge detected in the same cycle as its clear keeps the bit set.
- R8: Pending (word 4) reads raw status AND enable (word 2). `irq` is the OR of all pending bits.
- R9: Word 8 reads 3. Words 10 to 15 read 0. Writes to words 3, 4 and 8 have no effect. Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.
- R10: The pin count `NPINS` is a parameter of at most 32. Register bits at and above `NPINS` read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | NPINS | Pad levels |
| pin_oe | output | NPINS | Pad output enables |
| pin_do | output | NPINS | Pad output data |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an edge arriving in the very cycle its clear is written. That cycle is only reached by timing the clear write exactly three edges after the pad change. The pad change takes two synchronizer flops and one edge-detect flop to reach raw status. The bench makes the pad change, waits two clock edges, then issues the clear write so that its strobe lands on the status update. Mode changes are also applied while pins stay high or low. This shows that level-triggered status follows the input, while edge-triggered status holds until cleared.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] HW_VERSION = 32'd3;

  typedef enum logic [ADDR_W-1:0] {
    RG_LEVEL  = 4'd0,
    RG_DIR    = 4'd1,
    RG_ENABLE = 4'd2,
    RG_RAW    = 4'd3,
    RG_PEND   = 4'd4,
    RG_CLEAR  = 4'd5,
    RG_MODE   = 4'd6,
    RG_SENSE  = 4'd7,
    RG_VER    = 4'd8,
    RG_DUAL   = 4'd9
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] edge_en,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] dual_en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat
);
  logic [W-1:0] prev_q;
  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] rise, fall, edge_hit, lvl_hit;

  always_comb begin
    rise     = lvl & ~prev_q;
    fall     = ~lvl & prev_q;
    edge_hit = (dual_en & (rise | fall)) |
               (~dual_en & ((sense & rise) | (~sense & fall)));
    lvl_hit  = (sense & lvl) | (~sense & ~lvl);
    stat_d   = (edge_en & (edge_hit | (stat_q & ~clr))) | (~edge_en & lvl_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl;
      stat_q <= stat_d;
    end
  end

  assign stat = stat_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS    = 32,
  parameter bit HAS_DUAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_do,
  output logic              irq
);
  logic [NPINS-1:0] lvl_q_d, lvl_q_q;
  logic [NPINS-1:0] dir_d, dir_q;
  logic [NPINS-1:0] ena_d, ena_q;
  logic [NPINS-1:0] mode_d, mode_q;
  logic [NPINS-1:0] sense_d, sense_q;
  logic [NPINS-1:0] dual_d, dual_q, dual_eff;
  logic [NPINS-1:0] clr_pulse;
  logic [NPINS-1:0] pin_sync, raw_stat, pend;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic [NPINS-1:0] wdat;

  assign wdat = bus_wdata[NPINS-1:0];

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  generate
    if (HAS_DUAL) begin : g_dual
      assign dual_eff = dual_q;
    end else begin : g_no_dual
      assign dual_eff = '0;
    end
  endgenerate

  gpio_trig #(.W(NPINS)) u_trig (
    .clk(clk), .rst_n(rst_n), .lvl(pin_sync), .edge_en(mode_q),
    .sense(sense_q), .dual_en(dual_eff), .clr(clr_pulse), .stat(raw_stat)
  );

  assign pend = raw_stat & ena_q;

  // register write decode
  always_comb begin
    lvl_q_d   = lvl_q_q;
    dir_d     = dir_q;
    ena_d     = ena_q;
    mode_d    = mode_q;
    sense_d   = sense_q;
    dual_d    = dual_q;
    clr_pulse = '0;
    if (bus_wr) begin
      unique case (bus_addr)
        RG_LEVEL:  lvl_q_d   = wdat;
        RG_DIR:    dir_d     = wdat;
        RG_ENABLE: ena_d     = wdat;
        RG_CLEAR:  clr_pulse = wdat;
        RG_MODE:   mode_d    = wdat;
        RG_SENSE:  sense_d   = wdat;
        RG_DUAL:   dual_d    = HAS_DUAL ? wdat : '0;
        default:   ;
      endcase
    end
  end

  // read mux, zero-extended to the bus width
  always_comb begin
    rdata_d = '0;
    unique case (bus_addr)
      RG_LEVEL:  rdata_d[NPINS-1:0] = pin_sync;
      RG_DIR:    rdata_d[NPINS-1:0] = dir_q;
      RG_ENABLE: rdata_d[NPINS-1:0] = ena_q;
      RG_RAW:    rdata_d[NPINS-1:0] = raw_stat;
      RG_PEND:   rdata_d[NPINS-1:0] = pend;
      RG_MODE:   rdata_d[NPINS-1:0] = mode_q;
      RG_SENSE:  rdata_d[NPINS-1:0] = sense_q;
      RG_VER:    rdata_d            = HW_VERSION;
      RG_DUAL:   rdata_d[NPINS-1:0] = dual_q;
      default:   rdata_d            = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q_q <= '0;
      dir_q   <= '1;
      ena_q   <= '0;
      mode_q  <= '0;
      sense_q <= '1;
      dual_q  <= '0;
    end else if (bus_wr) begin
      lvl_q_q <= lvl_q_d;
      dir_q   <= dir_d;
      ena_q   <= ena_d;
      mode_q  <= mode_d;
      sense_q <= sense_d;
      dual_q  <= dual_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_oe    = ~dir_q;
  assign pin_do    = lvl_q_q;
  assign irq       = |pend;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  pin_do,
  input logic              irq
);
  // R2
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RG_DIR) |=> (pin_oe == ~$past(bus_wdata[NPINS-1:0])));

  // R3
  level_to_do_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RG_LEVEL) |=> (pin_do == $past(bus_wdata[NPINS-1:0])));

  // R8
  mask_all_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RG_ENABLE && bus_wdata[NPINS-1:0] == '0) |=> !irq);

  // R9
  version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == RG_VER) |=> (bus_rdata == HW_VERSION));

  // R9
  hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr > RG_DUAL) |=> (bus_rdata == '0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_oe(pin_oe), .pin_do(pin_do), .irq(irq)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int N = 12;
  localparam int MAXCYC = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_oe, pin_do;
  logic          irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_tag = "R1";

  gpio_irq_ctrl #(.NPINS(N)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_do(pin_do), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // behavioural reference state
  bit m_in1[N], m_in2[N], m_old[N], m_st[N];
  bit m_do[N], m_dir[N], m_en[N], m_md[N], m_se[N], m_du[N];
  logic [31:0] m_rdata = '0;
  bit rd_seen = 0;

  function automatic logic [31:0] pack(input bit v[N]);
    logic [31:0] r = '0;
    for (int i = 0; i < N; i++) r[i] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] r = '0;
    case (a)
      0: r = pack(m_in2);
      1: r = pack(m_dir);
      2: r = pack(m_en);
      3: r = pack(m_st);
      4: r = pack(m_st) & pack(m_en);
      6: r = pack(m_md);
      7: r = pack(m_se);
      8: r = 32'd3;
      9: r = pack(m_du);
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_in1[i] = 0; m_in2[i] = 0; m_old[i] = 0; m_st[i] = 0;
        m_do[i] = 0; m_dir[i] = 1; m_en[i] = 0; m_md[i] = 0; m_se[i] = 1; m_du[i] = 0;
      end
      m_rdata = '0;
      rd_seen = 0;
    end else begin
      rd_seen = bus_rd;
      if (bus_rd) m_rdata = model_read(int'(bus_addr));
      for (int i = 0; i < N; i++) begin
        bit up, dn, hit, clr;
        up  = m_in2[i] && !m_old[i];
        dn  = !m_in2[i] && m_old[i];
        clr = bus_wr && bus_addr == 4'd5 && bus_wdata[i];
        if (m_md[i]) begin
          if (m_du[i]) hit = up || dn;
          else hit = m_se[i] ? up : dn;
          m_st[i] = hit || (m_st[i] && !clr);
        end else begin
          m_st[i] = m_se[i] ? m_in2[i] : !m_in2[i];
        end
        m_old[i] = m_in2[i];
        m_in2[i] = m_in1[i];
        m_in1[i] = pin_in[i];
        if (bus_wr) begin
          case (bus_addr)
            4'd0: m_do[i]  = bus_wdata[i];
            4'd1: m_dir[i] = bus_wdata[i];
            4'd2: m_en[i]  = bus_wdata[i];
            4'd6: m_md[i]  = bus_wdata[i];
            4'd7: m_se[i]  = bus_wdata[i];
            4'd9: m_du[i]  = bus_wdata[i];
            default: ;
          endcase
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8 irq", {31'd0, irq}, {31'd0, |(pack(m_st) & pack(m_en))});
      check("R2 pin_oe", {20'd0, pin_oe}, ~pack(m_dir) & 32'hFFF);
      check("R3 pin_do", {20'd0, pin_do}, pack(m_do));
      if (rd_seen) check({cur_tag, " rdata"}, bus_rdata, m_rdata);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input int a);
    cur_tag = tag;
    bus_addr = 4'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 pin_oe", {20'd0, pin_oe}, 32'd0);
    check("R1 pin_do", {20'd0, pin_do}, 32'd0);
    rst_n = 1'b1;
    idle(2);
    for (int a = 0; a < 10; a++) rd("R1", a);

    // R2 direction
    wr(1, 32'h0000_00F0);
    rd("R2", 1);
    // R3 output data and input readback
    wr(0, 32'h0000_0A5A);
    pin_in = 12'h3C3;
    idle(3);
    rd("R3", 0);

    // R4 level sense, mixed polarity
    wr(2, 32'hFFF);
    wr(7, 32'h00F);
    idle(4);
    rd("R4", 3);
    pin_in = 12'h0F0;
    idle(4);
    rd("R4", 3);
    rd("R8", 4);

    // R5 edge mode
    wr(6, 32'hFFF);
    wr(7, 32'h0F0);
    wr(5, 32'hFFF);
    idle(4);
    rd("R5", 3);
    pin_in = 12'h00F;
    idle(5);
    rd("R5", 3);
    pin_in = 12'h0FF;
    idle(5);
    rd("R5", 3);

    // R6 dual edges on low nibble, sense bits ignored
    wr(9, 32'h00F);
    wr(5, 32'hFFF);
    pin_in = 12'h0F0;
    idle(5);
    rd("R6", 3);
    wr(7, 32'h000);
    wr(5, 32'hFFF);
    pin_in = 12'h0FF;
    idle(5);
    rd("R6", 3);
    rd("R9", 9);

    // R7 partial clear and zero write
    wr(5, 32'h003);
    rd("R7", 3);
    wr(5, 32'h000);
    rd("R7", 3);
    // R7 edge in the same cycle as its clear
    wr(5, 32'hFFF);
    pin_in = 12'h0FE;
    idle(2);
    wr(5, 32'h001);
    rd("R7", 3);

    // R8 mask
    wr(2, 32'h002);
    rd("R8", 4);
    wr(2, 32'h000);
    rd("R8", 4);

    // R9 version, holes, read-only writes
    rd("R9", 8);
    rd("R9", 12);
    rd("R9", 15);
    wr(3, 32'hFFF);
    wr(8, 32'h7);
    rd("R9", 3);
    rd("R9", 8);

    // R10 bits above pin count
    wr(1, 32'hFFFF_FFFF);
    rd("R10", 1);
    wr(6, 32'h0000_0000);
    wr(7, 32'hFFFF_F000);
    idle(4);
    rd("R10", 7);
    rd("R4", 3);

    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < MAXCYC; k++) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule